// File: doc/BRIEF.md
# Direction-Steered Byte FIFO

This block is a single-clock first-in first-out buffer for bytes. By default it holds 256 entries. It has no separate write and read strobes. One direction input decides what every rising clock edge does. When the direction input is 1, the edge stores the byte on the data input. When it is 0, the edge removes the oldest stored byte and places it on the data output register. An operation that would overflow a full buffer is dropped without effect, and so is an operation that would underflow an empty one. A producer and a consumer can therefore share one port and take turns on it without a guard of their own.

An occupancy state machine with three states steers the pointers:
- `OCC_EMPTY` takes *first-write* to `OCC_PART`.
- `OCC_PART` takes *last-read* (a read at occupancy 1) to `OCC_EMPTY`.
- `OCC_PART` takes *filling-write* (a write at occupancy DEPTH-1) to `OCC_FULL`.
- `OCC_FULL` takes *first-read* to `OCC_PART`.
- Every other cycle holds the state.

The write pointer and the read pointer are counters that wrap modulo DEPTH. A separate occupancy counter, one bit wider than the pointers, drives four combinational status flags. The almost-full and almost-empty levels are fixed when the design is elaborated.

Top module: `dirfifo_top`

## Requirements
- R1: With `wr_sel`=1 and `full`=0, a rising edge stores `din` and raises the occupancy by one.
- R2: With `wr_sel`=0 and `empty`=0, a rising edge loads the oldest unread byte into `dout`, where it is visible right after that edge, and lowers the occupancy by one. Bytes leave in the order they were written.
- R3: A write while `full`=1 is dropped. The occupancy and the stored contents do not change, and the dropped byte is never read out.
- R4: A read while `empty`=1 is dropped. `dout` keeps its previous value and the occupancy stays 0.
- R5: `empty` is 1 exactly when the occupancy is 0.
- R6: `full` is 1 exactly when the occupancy equals DEPTH (256).
- R7: `almost_full` is 1 exactly when the occupancy is at least AF_LEVEL (248).
- R8: `almost_empty` is 1 exactly when the occupancy is at most AE_LEVEL (8).
- R9: While `rst_n` is 0, the pointers and the occupancy are cleared asynchronously and `dout` is cleared to 0. `empty` and `almost_empty` read 1, and `full` and `almost_full` read 0.
- R10: The pointers wrap past DEPTH-1 to 0 without breaking the first-in first-out order.
- R11: The state machine follows only the named transitions (first-write, last-read, filling-write, first-read). `OCC_EMPTY` is held exactly when the occupancy is 0, and `OCC_FULL` exactly when it is DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_sel | input | 1 | 1 = write `din` this edge, 0 = read |
| din | input | 8 | Byte to store |
| dout | output | 8 | Last byte read out (registered) |
| empty | output | 1 | Occupancy is 0 |
| full | output | 1 | Occupancy is DEPTH |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL |
| almost_empty | output | 1 | Occupancy at or below AE_LEVEL |

## Verification
A short run of three writes and three reads checks byte order and the single-step flag changes away from any boundary. A fill of all 256 entries, with writes pushed past full, drives the occupancy through 8/9, 247/248 and 255/256. This tells an off-by-one threshold apart from a correct one, and a dropped write apart from one that corrupts memory. A full drain followed by reads on an empty buffer separates a held `dout` from a stale or repeated read. A long mixed run, writing twice for every read and then reading twice for every write, carries both pointers across the wrap while the occupancy sits mid-range. This separates correct modulo arithmetic from pointer aliasing.

// File: rtl/dirfifo_pkg.sv
package dirfifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/dirfifo_ctrl.sv
module dirfifo_ctrl
    import dirfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    occ_state_t state, state_nxt;

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OCC_EMPTY;
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            state <= state_nxt;
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
                count  <= count + 1'b1;
            end else if (rd_en) begin
                rd_ptr <= rd_ptr + 1'b1;
                count  <= count - 1'b1;
            end
        end
    end

    // transitions: first-write, last-read, filling-write, first-read
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: if (wr_sel) state_nxt = OCC_PART;
            OCC_PART: begin
                if (wr_sel && count == CNT_LAST)      state_nxt = OCC_FULL;
                else if (!wr_sel && count == CNT_ONE) state_nxt = OCC_EMPTY;
            end
            OCC_FULL:  if (!wr_sel) state_nxt = OCC_PART;
            default:   state_nxt = OCC_EMPTY;
        endcase
    end

    // operation enables
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state)
            OCC_EMPTY: wr_en = wr_sel;
            OCC_PART: begin
                wr_en = wr_sel;
                rd_en = !wr_sel;
            end
            OCC_FULL:  rd_en = !wr_sel;
            default: ;
        endcase
    end

    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && count != CNT_FULL) |=> (count == $past(count) + 1'b1));

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && count != '0) |=> (count == $past(count) - 1'b1));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && count == CNT_FULL) |=> (count == CNT_FULL && $stable(wr_ptr)));

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && count == '0) |=> (count == '0 && $stable(rd_ptr)));

    a_r11_empty_track: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_EMPTY) == (count == '0));

    a_r11_full_track: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL) == (count == CNT_FULL));

    a_r11_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: rtl/dirfifo_store.sv
module dirfifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [AW-1:0]     rd_ptr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout <= '0;
        else if (rd_en) dout <= mem[rd_ptr];
    end

    a_r4_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout));

endmodule

// File: rtl/dirfifo_flags.sv
module dirfifo_flags #(
    parameter int DEPTH    = 256,
    parameter int AF_LEVEL = 248,
    parameter int AE_LEVEL = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          almost_full,
    output logic          almost_empty
);

    always_comb begin
        empty        = (count == '0);
        full         = (count == CW'(DEPTH));
        almost_full  = (count >= CW'(AF_LEVEL));
        almost_empty = (count <= CW'(AE_LEVEL));
    end

    a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r7_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);

    a_r8_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);

endmodule

// File: rtl/dirfifo_top.sv
module dirfifo_top #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 256,
    parameter int AF_LEVEL = 248,
    parameter int AE_LEVEL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic              almost_full,
    output logic              almost_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    dirfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count)
    );

    dirfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .din    (din),
        .dout   (dout)
    );

    dirfifo_flags #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (count),
        .empty        (empty),
        .full         (full),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    a_r10_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - rd_ptr) == count[AW-1:0]);

endmodule

// File: tb/dirfifo_top_test.sv
`timescale 1ns/1ps
module dirfifo_top_test;

    localparam int DEPTH = 256;
    localparam int AF    = 248;
    localparam int AE    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       empty, full, almost_full, almost_empty;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_q[$];
    logic [7:0] exp_dout = '0;

    always #2 clk = ~clk;

    dirfifo_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_sel       (wr_sel),
        .din          (din),
        .dout         (dout),
        .empty        (empty),
        .full         (full),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_flags();
        int n = model_q.size();
        check("R5 empty", int'(empty), int'(n == 0));
        check("R6 full", int'(full), int'(n == DEPTH));
        check("R7 almost_full", int'(almost_full), int'(n >= AF));
        check("R8 almost_empty", int'(almost_empty), int'(n <= AE));
    endtask

    // one clock edge with a given direction; model updated from the requirements
    task automatic step(input logic dir, input logic [7:0] data, input string req);
        @(negedge clk);
        wr_sel = dir;
        din    = data;
        @(posedge clk);
        #1;
        if (dir) begin
            if (model_q.size() < DEPTH) model_q.push_back(data);
        end else begin
            if (model_q.size() > 0) exp_dout = model_q.pop_front();
        end
        check(req, int'(dout), int'(exp_dout));
        check_flags();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        model_q.delete();
        exp_dout = '0;
        #5;
        check("R9 dout", int'(dout), 0);
        check("R9 empty", int'(empty), 1);
        check("R9 almost_empty", int'(almost_empty), 1);
        check("R9 full", int'(full), 0);
        check("R9 almost_full", int'(almost_full), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_short();
        step(1'b1, 8'hA5, "R1 write");
        step(1'b1, 8'h3C, "R1 write");
        step(1'b1, 8'hF0, "R1 write");
        step(1'b0, 8'h00, "R2 read order");
        step(1'b0, 8'h00, "R2 read order");
        step(1'b0, 8'h00, "R11 last-read");
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i * 3 + 1), "R11 filling-write");
        for (int i = 0; i < 4; i++) step(1'b1, 8'hEE, "R3 write while full");
        step(1'b0, 8'h00, "R11 first-read");
        step(1'b1, 8'h77, "R1 refill");
        for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, "R3 drain order");
    endtask

    task automatic t_underflow();
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, "R4 read while empty");
        step(1'b1, 8'h5A, "R11 first-write");
        step(1'b0, 8'h00, "R2 read after underflow");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 800; i++) begin
            logic d = (i < 400) ? (i % 3 != 0) : (i % 3 == 0);
            step(d, 8'(i * 37 + 5), "R10 wrap order");
        end
        while (model_q.size() > 0) step(1'b0, 8'h00, "R10 final drain");
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_short();
        t_fill_overflow();
        t_underflow();
        t_wrap();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule